// File: doc/BRIEF.md
# Sixteen-bit multi-mode timer with pulse-density output

The block is a 16-bit counter that an eight-bit register bus configures. It advances on a clock-enable strobe after that strobe passes through a power-of-two prescaler. It has three modes. In sawtooth mode it counts up and returns to zero. In triangle mode it counts up and back down between zero and a programmed period. In the third mode it stops counting and becomes a first-order sigma-delta modulator: the period value is the input level, and the modulator produces a one-bit pulse-density stream on a single output pin.

Software sets the period and the counter one byte at a time. An optional shadow copy of the period lets a new value take effect only where one counting cycle ends. An optional high-byte holding register makes 16-bit counter reads and writes atomic, even though the bus moves one byte per access. A one-cycle event strobe marks every return to zero.

Top module: `tmr16_core`

## Requirements
- R1: Reset (synchronous, active-low) clears the counter, the modulator accumulator, the active and shadow periods, the control register, `period_evt` and `pdm_out`.
- R2: Control register (address 0) layout: bit 0 enable, bits 2:1 mode (00 sawtooth, 01 triangle, 10 pulse density, 11 treated as sawtooth), bit 3 period shadowing, bit 4 high-byte holding, bits 7:5 prescale code. In sawtooth mode with period P, n counter ticks after zero leave the counter at n mod (P+1). `period_evt` pulses once per wrap, so n ticks give floor(n/(P+1)) pulses.
- R3: In triangle mode with period P ≥ 1, after n ticks from zero the counter equals t when t ≤ P and equals 2P−t otherwise, where t = n mod 2P. `period_evt` pulses once each time the count returns to zero, giving floor(n/2P) pulses.
- R4: In pulse-density mode each tick adds the period to a 16-bit accumulator, and `pdm_out` takes the carry out of that addition and holds it until the next tick. After n ticks from reset the output has been high for floor(n·P/65536) ticks. In the other modes `pdm_out` stays 0.
- R5: With prescale code k, the counter advances once for every 2^k `src_tick` strobes. After M strobes from enable the counter has advanced floor(M/2^k).
- R6: While the enable bit is 0, `src_tick` strobes leave the counter unchanged and produce no `period_evt`.
- R7: With period shadowing on, period writes (address 1 low byte, address 2 high byte) go to the shadow. The active period, which reads return, changes only where a counting cycle ends (wrap or return to zero) or on a pulse-density tick. With shadowing off, writes take effect at once.
- R8: With high-byte holding on, a read strobe on the counter low byte (address 3) captures the high byte. Later reads of address 4 return that captured value even if the counter has moved since.
- R9: With high-byte holding on, a write to address 4 does not change the counter. The next write to address 3 loads both bytes in one cycle.
- R10: With high-byte holding off, writes to address 3 or 4 change only that byte at once, and reads of address 4 return the live high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_tick | input | 1 | Count-source clock enable, one strobe per source event |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe (matters for the counter low byte) |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register, combinational |
| pdm_out | output | 1 | Pulse-density output |
| period_evt | output | 1 | One-cycle strobe at each wrap or return to zero |

## Verification
The embedded properties assume a few things about the inputs. A counter freeze is checked only in cycles with no counter write on the bus. The held-high-byte property needs the write to address 4 to fall in a cycle with no counting tick. The shadowed-period property expects the shadow enable to be sampled in the same cycle as the write it governs. The bench keeps to these assumptions: every count-source strobe is a single cycle followed by an idle cycle, bus writes and reads never share a cycle with a strobe, and each sweep starts from a fresh reset with the period programmed before the enable is set. The mid-run control writes, used for shadowing and holding, happen only between strobes.

// File: rtl/tmr16_pkg.sv
// Package: shared register addresses, mode encoding and control layout for
// the multi-mode timer. Assumes an 8-bit register bus.
package tmr16_pkg;

    localparam int PSEL_W = 3;   // prescale code width (ratio 2^code)
    localparam int ADDR_W = 3;   // register address width

    localparam logic [ADDR_W-1:0] ADR_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_PER_LO = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_PER_HI = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_CNT_LO = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_CNT_HI = 3'd4;

    typedef enum logic [1:0] {
        MODE_SAW = 2'd0,
        MODE_TRI = 2'd1,
        MODE_PDM = 2'd2,
        MODE_RSV = 2'd3
    } tmr_mode_e;

    // Control byte, MSB first: psel[7:5] hold[4] shadow[3] mode[2:1] en[0]
    typedef struct packed {
        logic [PSEL_W-1:0] psel;
        logic              hold;
        logic              shadow;
        tmr_mode_e         mode;
        logic              en;
    } ctrl_t;

endpackage

// File: rtl/tmr16_prescale.sv
// Prescaler: passes one of every 2^psel source strobes as a count tick.
// Assumes psel is a register value; the divider restarts while not running.
module tmr16_prescale #(
    parameter int PSW = 3
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           run,
    input  logic           src_tick,
    input  logic [PSW-1:0] psel,
    output logic           tick
);
    localparam int DIVW = (1 << PSW) - 1;

    logic [DIVW-1:0] div_q;
    logic [DIVW-1:0] mask;

    // Low-bit mask of the divider that must be all ones to release a tick
    always_comb begin
        mask = (DIVW'(1) << psel) - DIVW'(1);
        tick = run && src_tick && ((div_q & mask) == mask);
    end

    // Source-strobe divider, held at zero while the timer is disabled
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            div_q <= '0;
        end else if (src_tick) begin
            div_q <= div_q + DIVW'(1);
        end
    end

    // A tick with a ratio above one cannot repeat on the next cycle
    AST_TICK_SPACED: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psel != '0) |=> (!tick || psel != $past(psel))); // R5

endmodule

// File: rtl/tmr16_count.sv
// Up / up-down counter: sawtooth wraps after reaching the period, triangle
// turns at the period and at zero. Assumes the period is a register value.
module tmr16_count #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic          tri_mode,
    input  logic [CW-1:0] per,
    input  logic          wr_en,
    input  logic [CW-1:0] wr_val,
    output logic [CW-1:0] cnt,
    output logic          evt,
    output logic          boundary
);
    logic [CW-1:0] cnt_q, nxt;
    logic          up_q, nxt_up, hit, evt_q;

    // Next count, direction and zero-return flag for one tick
    always_comb begin
        nxt    = cnt_q;
        nxt_up = up_q;
        hit    = 1'b0;
        if (!tri_mode) begin
            nxt_up = 1'b1;
            if (cnt_q >= per) begin
                nxt = '0;
                hit = 1'b1;
            end else begin
                nxt = cnt_q + CW'(1);
            end
        end else if (up_q) begin
            if (cnt_q >= per) begin
                if (cnt_q <= CW'(1)) begin
                    nxt    = '0;
                    hit    = 1'b1;
                    nxt_up = 1'b1;
                end else begin
                    nxt    = cnt_q - CW'(1);
                    nxt_up = 1'b0;
                end
            end else begin
                nxt = cnt_q + CW'(1);
            end
        end else begin
            if (cnt_q <= CW'(1)) begin
                nxt    = '0;
                hit    = 1'b1;
                nxt_up = 1'b1;
            end else begin
                nxt = cnt_q - CW'(1);
            end
        end
    end

    // Counter state: bus write first, then tick; event strobe lasts one cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            up_q  <= 1'b1;
            evt_q <= 1'b0;
        end else begin
            evt_q <= 1'b0;
            if (wr_en) begin
                cnt_q <= wr_val;
            end else if (tick) begin
                cnt_q <= nxt;
                up_q  <= nxt_up;
                evt_q <= hit;
            end
        end
    end

    assign cnt      = cnt_q;
    assign evt      = evt_q;
    assign boundary = tick && !wr_en && hit;

    AST_EVT_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        evt_q |-> (cnt_q == '0)); // R2
    AST_TRI_NO_OVERSHOOT: assert property (@(posedge clk) disable iff (!rst_n)
        (tri_mode && tick && !wr_en && cnt_q >= per && per != '0) |=> (cnt_q < $past(cnt_q))); // R3

endmodule

// File: rtl/tmr16_pdm.sv
// First-order sigma-delta modulator: adds the level on each tick and emits
// the carry. Assumes level is a register value.
module tmr16_pdm #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          tick,
    input  logic [CW-1:0] level,
    output logic          bit_out
);
    logic [CW-1:0] acc_q;
    logic          bit_q;
    logic [CW:0]   sum;

    // Accumulator plus level, with the carry in the top bit
    always_comb sum = {1'b0, acc_q} + {1'b0, level};

    // Accumulate on each tick and hold the carry until the next one
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q <= '0;
            bit_q <= 1'b0;
        end else if (tick) begin
            acc_q <= sum[CW-1:0];
            bit_q <= sum[CW];
        end
    end

    assign bit_out = bit_q;

    AST_PDM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(bit_q)); // R4
    AST_PDM_ZERO_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && level == '0) |=> !bit_q); // R4

endmodule

// File: rtl/tmr16_regs.sv
// Register file: control byte, active/shadow period and byte holding for
// atomic 16-bit counter access. Assumes one bus access per cycle.
module tmr16_regs
    import tmr16_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            bus_we,
    input  logic            bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]   bus_wdata,
    output logic [DW-1:0]   bus_rdata,
    input  logic            boundary,
    input  logic [2*DW-1:0] cnt,
    output ctrl_t           ctrl,
    output logic [2*DW-1:0] per_act,
    output logic            cnt_wr_en,
    output logic [2*DW-1:0] cnt_wr_val
);
    localparam int CW = 2 * DW;

    ctrl_t         ctrl_q;
    logic [CW-1:0] act_q, shd_q;
    logic [DW-1:0] wr_hold_q, rd_hold_q;

    // Register writes, shadow transfer at a boundary, high-byte capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q    <= '0;
            act_q     <= '0;
            shd_q     <= '0;
            wr_hold_q <= '0;
            rd_hold_q <= '0;
        end else begin
            if (boundary && ctrl_q.shadow) begin
                act_q <= shd_q;
            end
            if (bus_we) begin
                case (bus_addr)
                    ADR_CTRL: ctrl_q <= ctrl_t'(bus_wdata[7:0]);
                    ADR_PER_LO: begin
                        shd_q[DW-1:0] <= bus_wdata;
                        if (!ctrl_q.shadow) act_q[DW-1:0] <= bus_wdata;
                    end
                    ADR_PER_HI: begin
                        shd_q[CW-1:DW] <= bus_wdata;
                        if (!ctrl_q.shadow) act_q[CW-1:DW] <= bus_wdata;
                    end
                    ADR_CNT_HI: if (ctrl_q.hold) wr_hold_q <= bus_wdata;
                    default: ;
                endcase
            end
            if (bus_re && bus_addr == ADR_CNT_LO) begin
                rd_hold_q <= cnt[CW-1:DW];
            end
        end
    end

    // Counter load request and the merged 16-bit value
    always_comb begin
        cnt_wr_en  = 1'b0;
        cnt_wr_val = cnt;
        if (bus_we && bus_addr == ADR_CNT_LO) begin
            cnt_wr_en  = 1'b1;
            cnt_wr_val = ctrl_q.hold ? {wr_hold_q, bus_wdata} : {cnt[CW-1:DW], bus_wdata};
        end else if (bus_we && bus_addr == ADR_CNT_HI && !ctrl_q.hold) begin
            cnt_wr_en  = 1'b1;
            cnt_wr_val = {bus_wdata, cnt[DW-1:0]};
        end
    end

    // Read data multiplexer
    always_comb begin
        case (bus_addr)
            ADR_CTRL:   bus_rdata = DW'(ctrl_q);
            ADR_PER_LO: bus_rdata = act_q[DW-1:0];
            ADR_PER_HI: bus_rdata = act_q[CW-1:DW];
            ADR_CNT_LO: bus_rdata = cnt[DW-1:0];
            ADR_CNT_HI: bus_rdata = ctrl_q.hold ? rd_hold_q : cnt[CW-1:DW];
            default:    bus_rdata = '0;
        endcase
    end

    assign ctrl    = ctrl_q;
    assign per_act = act_q;

    AST_PER_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_q.shadow && !boundary) |=> $stable(act_q)); // R7

endmodule

// File: rtl/tmr16_core.sv
// Top: 16-bit multi-mode timer (sawtooth, triangle, pulse density) with a
// byte-wide register bus. Assumes src_tick is synchronous to clk.
module tmr16_core
    import tmr16_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_tick,
    input  logic              bus_we,
    input  logic              bus_re,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              pdm_out,
    output logic              period_evt
);
    localparam int CW = 2 * DW;

    ctrl_t         ctrl;
    logic [CW-1:0] per_act, cnt, cnt_wr_val;
    logic          cnt_wr_en, pre_tick, cnt_tick, pdm_tick;
    logic          cnt_boundary, boundary, pdm_bit, is_pdm;

    // Mode steering of the prescaled tick
    always_comb begin
        is_pdm   = (ctrl.mode == MODE_PDM);
        cnt_tick = pre_tick && !is_pdm;
        pdm_tick = pre_tick && is_pdm;
        boundary = cnt_boundary || pdm_tick;
        pdm_out  = pdm_bit && is_pdm;
    end

    tmr16_regs #(.DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .boundary(boundary), .cnt(cnt), .ctrl(ctrl), .per_act(per_act),
        .cnt_wr_en(cnt_wr_en), .cnt_wr_val(cnt_wr_val)
    );

    tmr16_prescale #(.PSW(PSEL_W)) u_pre (
        .clk(clk), .rst_n(rst_n), .run(ctrl.en), .src_tick(src_tick),
        .psel(ctrl.psel), .tick(pre_tick)
    );

    tmr16_count #(.CW(CW)) u_cnt (
        .clk(clk), .rst_n(rst_n), .tick(cnt_tick),
        .tri_mode(ctrl.mode == MODE_TRI), .per(per_act),
        .wr_en(cnt_wr_en), .wr_val(cnt_wr_val),
        .cnt(cnt), .evt(period_evt), .boundary(cnt_boundary)
    );

    tmr16_pdm #(.CW(CW)) u_pdm (
        .clk(clk), .rst_n(rst_n), .tick(pdm_tick), .level(per_act),
        .bit_out(pdm_bit)
    );

    AST_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.en && !cnt_wr_en) |=> $stable(cnt)); // R6
    AST_NO_EVT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl.en |=> !period_evt); // R6
    AST_HI_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl.hold && bus_we && bus_addr == ADR_CNT_HI && !cnt_tick) |=> $stable(cnt)); // R9

endmodule

// File: tb/tmr16_core_tb.sv
// Bench: near-exhaustive sweeps of small periods and all prescale codes,
// expected values computed arithmetically from the requirements.
module tmr16_core_tb;
    import tmr16_pkg::*;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0, rst_n = 1'b0, src_tick = 1'b0;
    logic       bus_we = 1'b0, bus_re = 1'b0;
    logic [2:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       pdm_out, period_evt;

    int n_vec = 0, n_bad = 0, evt_seen = 0, pdm_seen = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tmr16_core u_dut (
        .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
        .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pdm_out(pdm_out), .period_evt(period_evt)
    );

    task automatic check(string req, longint act, longint exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk) rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        evt_seen = 0;
        pdm_seen = 0;
    endtask

    task automatic wr(logic [2:0] a, logic [7:0] d);
        @(negedge clk);
        bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk) bus_we = 1'b0;
    endtask

    task automatic rd(logic [2:0] a, logic re, output int d);
        @(negedge clk);
        bus_addr = a; bus_re = re;
        #1 d = int'(bus_rdata);
        @(negedge clk) bus_re = 1'b0;
    endtask

    task automatic rd_cnt(output int v);
        int lo, hi;
        rd(ADR_CNT_LO, 1'b1, lo);
        rd(ADR_CNT_HI, 1'b0, hi);
        v = (hi << 8) | lo;
    endtask

    task automatic set_per(int p);
        wr(ADR_PER_LO, 8'(p));
        wr(ADR_PER_HI, 8'(p >> 8));
    endtask

    task automatic pulse(int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) src_tick = 1'b1;
            @(negedge clk) src_tick = 1'b0;
            evt_seen += int'(period_evt);
            pdm_seen += int'(pdm_out);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog (all requirements) actual=timeout expected=finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        int v, a;
        // R1: reset state
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        rd_cnt(v);              check("R1 counter", v, 0);
        rd(ADR_PER_LO, 0, v);   check("R1 period lo", v, 0);
        rd(ADR_PER_HI, 0, v);   check("R1 period hi", v, 0);
        rd(ADR_CTRL, 0, v);     check("R1 control", v, 0);
        check("R1 pdm", pdm_out, 0);
        check("R1 evt", period_evt, 0);

        // R2: sawtooth sweep over small periods, every tick
        for (int p = 0; p <= 6; p++) begin
            int n;
            do_reset();
            set_per(p);
            wr(ADR_CTRL, 8'h01);
            n = 0;
            for (int k = 0; k < 2 * (p + 1) + 1; k++) begin
                pulse(1);
                n++;
                rd_cnt(v);
                check($sformatf("R2 saw count P=%0d n=%0d", p, n), v, n % (p + 1));
            end
            check($sformatf("R2 saw events P=%0d", p), evt_seen, n / (p + 1));
            check("R4 pdm low outside pdm mode", pdm_seen, 0);
        end

        // R3: triangle sweep
        for (int p = 1; p <= 5; p++) begin
            int n;
            do_reset();
            set_per(p);
            wr(ADR_CTRL, 8'h03);
            n = 0;
            for (int k = 0; k < 4 * p + 1; k++) begin
                int t;
                pulse(1);
                n++;
                t = n % (2 * p);
                rd_cnt(v);
                check($sformatf("R3 tri count P=%0d n=%0d", p, n), v, (t <= p) ? t : 2 * p - t);
            end
            check($sformatf("R3 tri events P=%0d", p), evt_seen, n / (2 * p));
        end

        // R4: pulse density for several levels
        foreach (a_lv[i]) begin end
        for (int i = 0; i < 6; i++) begin
            int lv;
            case (i)
                0: lv = 0;
                1: lv = 16'h4000;
                2: lv = 16'h1000;
                3: lv = 16'hFFFF;
                4: lv = 16'h8001;
                default: lv = 16'h0555;
            endcase
            do_reset();
            set_per(lv);
            wr(ADR_CTRL, 8'h05);
            pulse(64);
            check($sformatf("R4 density level=%0h", lv), pdm_seen, (longint'(64) * lv) >> 16);
        end

        // R5: every prescale code
        for (int k = 0; k < 8; k++) begin
            do_reset();
            set_per(16'hFFFF);
            wr(ADR_CTRL, 8'((k << 5) | 1));
            pulse(259);
            rd_cnt(v);
            check($sformatf("R5 prescale code=%0d", k), v, 259 >> k);
        end

        // R6: disable freezes the counter
        do_reset();
        set_per(16'hFFFF);
        wr(ADR_CTRL, 8'h01);
        pulse(5);
        wr(ADR_CTRL, 8'h00);
        evt_seen = 0;
        pulse(10);
        rd_cnt(v);
        check("R6 frozen count", v, 5);
        check("R6 no events", evt_seen, 0);

        // R7: shadowed period takes effect at the wrap
        do_reset();
        set_per(5);
        wr(ADR_CTRL, 8'h09);
        pulse(2);
        wr(ADR_PER_LO, 8'd2);
        rd(ADR_PER_LO, 0, v);  check("R7 active held", v, 5);
        pulse(4);
        rd_cnt(v);             check("R7 old period wrap", v, 0);
        rd(ADR_PER_LO, 0, v);  check("R7 active updated", v, 2);
        pulse(3);
        rd_cnt(v);             check("R7 new period wrap", v, 0);
        check("R7 events", evt_seen, 2);
        wr(ADR_CTRL, 8'h01);
        wr(ADR_PER_LO, 8'd9);
        rd(ADR_PER_LO, 0, a);  check("R7 direct write", a, 9);

        // R8: captured high byte on read
        do_reset();
        set_per(16'hFFFF);
        wr(ADR_CTRL, 8'h11);
        wr(ADR_CNT_LO, 8'hFF);
        rd(ADR_CNT_LO, 1, v);  check("R8 low byte", v, 8'hFF);
        pulse(1);
        rd(ADR_CNT_HI, 0, v);  check("R8 captured high", v, 8'h00);
        wr(ADR_CTRL, 8'h01);
        rd(ADR_CNT_HI, 0, v);  check("R10 live high", v, 8'h01);

        // R9: held high-byte write
        wr(ADR_CTRL, 8'h11);
        wr(ADR_CNT_HI, 8'h12);
        rd_cnt(v);             check("R9 high write held", v, 16'h0100);
        wr(ADR_CNT_LO, 8'h34);
        rd_cnt(v);             check("R9 joint load", v, 16'h1234);

        // R10: direct byte writes
        wr(ADR_CTRL, 8'h01);
        wr(ADR_CNT_HI, 8'hAB);
        rd_cnt(v);             check("R10 direct high", v, 16'hAB34);
        wr(ADR_CNT_LO, 8'hCD);
        rd_cnt(v);             check("R10 direct low", v, 16'hABCD);

        // R1: reset clears periods and counter after use
        do_reset();
        rd(ADR_PER_HI, 0, v);  check("R1 period cleared", v, 0);
        rd_cnt(v);             check("R1 counter cleared", v, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    int a_lv[1] = '{0};

endmodule